// File: doc/BRIEF.md
# Multi-Function Timer Bank

This block holds a bank of identical 16-bit timers behind a small register bus. Each timer has four registers: a setup word, a counter that software can write directly, and two compare values. The counter advances on a tick made by a power-of-two prescaler. The prescaler is fed either by the system clock or by strobes from a slow reference clock. When the counter meets compare 1 or compare 2, the timer raises a sticky event flag. A compare-2 event also sends the counter back to zero.

The setup word takes a full write only once after reset. After that first write, only the run bit can change, and the two event flags can be cleared by writing a 1 to them. The prescaler, the clock source and the compare enables stay as they were until the next reset. A timer that has never been set up reads its setup word as zero, so software can scan the bank for a free timer.

For watchdog use, two enable vectors sit outside the timers, with one bit per timer in each. One vector gates a system reset request and the other gates an NMI request. Each request is a one-cycle pulse, raised when a timer's compare-2 flag goes from clear to set while that timer's enable bit is 1.

Top module: `mfgt_bank`

## Requirements
- R1: After reset, every register of every timer reads zero, and reset_req and nmi_req are low.
- R2: The first setup write after reset loads all fields. The setup word layout is: bits [3:0] prescale exponent d, bit 4 clock source (1 = system clock, 0 = ref_tick strobes), bit 5 compare-1 enable, bit 6 compare-2 enable, bit 13 compare-1 event, bit 14 compare-2 event, bit 15 run. All other bits read zero.
- R3: Every later setup write changes only the run bit and the event bits. Bits [6:0] keep the value from the first write until reset.
- R4: While run is 1, the counter advances once every 2^d clock-source strobes. With ref_tick low and clock source 0, the counter does not move.
- R5: Clearing run freezes the counter. Setting run again resumes counting from the frozen value.
- R6: On a tick where the counter equals compare 2 and compare 2 is enabled, the compare-2 event is set and the counter becomes 0. On a tick where the counter equals compare 1 and compare 1 is enabled, the compare-1 event is set and counting continues.
- R7: Event flags are sticky. Writing 1 to an event bit clears it, and writing 0 leaves it unchanged.
- R8: reset_req is high for exactly one cycle, in the cycle after the edge where a timer's compare-2 event goes from clear to set while its rst_enable bit is 1. No pulse occurs when the bit is 0 or when the flag was already set.
- R9: nmi_req follows the same rule as R8, gated by nmi_enable.
- R10: The counter saturates at 0xFFFF instead of wrapping.
- R11: A counter write loads the value and restarts the prescaler phase. In the cycle of that write, the compare check is skipped, so an old value equal to compare 2 does not set an event.
- R12: bus_addr is {timer index, select}, where select 0 = setup, 1 = counter, 2 = compare 1, 3 = compare 2. bus_rdata is registered one cycle after bus_rd. An index of NUM_TIMERS or above reads zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Timer index and register select |
| bus_wdata | input | 16 | Write data |
| ref_tick | input | 1 | Strobe from the slow reference clock |
| rst_enable | input | 6 | Per-timer gate for the reset request |
| nmi_enable | input | 6 | Per-timer gate for the NMI request |
| bus_rdata | output | 16 | Registered read data |
| reset_req | output | 1 | One-cycle system reset request |
| nmi_req | output | 1 | One-cycle NMI request |

## Verification
The bench places a counter write on the exact cycle in which the old count equals compare 2. A design that lets the stale match win would set the event flag and restart from zero instead of continuing from the loaded value. It also rewrites the configuration bits after the first setup write, which would expose a design whose lock leaks. It watches the request outputs over a long window to catch a pulse that repeats while the flag stays set or that fires with its enable bit clear. Runs near 0xFFFF show up wrap-around, and divided runs show up an off-by-one prescaler phase.

// File: rtl/mfgt_pkg.sv
package mfgt_pkg;
  localparam int DATA_W     = 16;
  localparam int DIV_W      = 4;
  localparam int CFG_W      = DIV_W + 3;
  localparam int BIT_CLKSEL = DIV_W;
  localparam int BIT_C1EN   = DIV_W + 1;
  localparam int BIT_C2EN   = DIV_W + 2;
  localparam int BIT_EV1    = 13;
  localparam int BIT_EV2    = 14;
  localparam int BIT_RUN    = 15;

  typedef enum logic [1:0] {
    SEL_SETUP = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CMP1  = 2'd2,
    SEL_CMP2  = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             c2_en;
    logic             c1_en;
    logic             clk_sel;
    logic [DIV_W-1:0] div;
  } cfg_t;

  function automatic cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
    cfg_t c;
    c.div     = w[DIV_W-1:0];
    c.clk_sel = w[BIT_CLKSEL];
    c.c1_en   = w[BIT_C1EN];
    c.c2_en   = w[BIT_C2EN];
    return c;
  endfunction
endpackage

// File: rtl/mfgt_prescaler.sv
module mfgt_prescaler #(
  parameter int DIV_W = 4,
  parameter int PH_W  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [PH_W-1:0] phase;
  logic [PH_W:0]   span;
  logic [PH_W-1:0] mask;

  always_comb begin
    span = (PH_W+1)'(1) << div;
    mask = PH_W'(span - (PH_W+1)'(1));
    tick = step && ((phase & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase <= '0;
    end else if (step) begin
      phase <= tick ? '0 : phase + PH_W'(1);
    end
  end
endmodule

// File: rtl/mfgt_channel.sv
module mfgt_channel
  import mfgt_pkg::*;
#(
  parameter int PH_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic [1:0]        wr_reg,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ref_tick,
  input  logic              rst_en,
  input  logic              nmi_en,
  output logic [DATA_W-1:0] setup_rd,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] cmp1_q,
  output logic [DATA_W-1:0] cmp2_q,
  output logic              rst_pulse,
  output logic              nmi_pulse
);
  localparam logic [DATA_W-1:0] CNT_MAX = '1;

  cfg_t cfg_q;
  logic locked, run_q, ev1_q, ev2_q;
  logic wr_setup, wr_count, wr_cmp1, wr_cmp2;
  logic src, step, tick_raw, tick, hit1, hit2, clr1, clr2;

  always_comb begin
    wr_setup = sel_wr && (wr_reg == SEL_SETUP);
    wr_count = sel_wr && (wr_reg == SEL_COUNT);
    wr_cmp1  = sel_wr && (wr_reg == SEL_CMP1);
    wr_cmp2  = sel_wr && (wr_reg == SEL_CMP2);
    clr1     = wr_setup && wdata[BIT_EV1];
    clr2     = wr_setup && wdata[BIT_EV2];
    src      = cfg_q.clk_sel ? 1'b1 : ref_tick;
    step     = run_q && src;
    tick     = tick_raw && !wr_count;
    hit1     = tick && cfg_q.c1_en && (count_q == cmp1_q);
    hit2     = tick && cfg_q.c2_en && (count_q == cmp2_q);
  end

  mfgt_prescaler #(.DIV_W(DIV_W), .PH_W(PH_W)) u_presc (
    .clk   (clk),
    .rst   (rst),
    .clear (wr_count || (wr_setup && !locked)),
    .step  (step),
    .div   (cfg_q.div),
    .tick  (tick_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      locked    <= 1'b0;
      run_q     <= 1'b0;
      ev1_q     <= 1'b0;
      ev2_q     <= 1'b0;
      count_q   <= '0;
      cmp1_q    <= '0;
      cmp2_q    <= '0;
      rst_pulse <= 1'b0;
      nmi_pulse <= 1'b0;
    end else begin
      if (wr_setup) begin
        run_q <= wdata[BIT_RUN];
        if (!locked) begin
          cfg_q  <= cfg_from_word(wdata);
          locked <= 1'b1;
        end
      end
      ev1_q <= hit1 || (ev1_q && !clr1);
      ev2_q <= hit2 || (ev2_q && !clr2);
      if (wr_count)                       count_q <= wdata;
      else if (hit2)                      count_q <= '0;
      else if (tick && count_q != CNT_MAX) count_q <= count_q + DATA_W'(1);
      if (wr_cmp1) cmp1_q <= wdata;
      if (wr_cmp2) cmp2_q <= wdata;
      rst_pulse <= hit2 && !ev2_q && rst_en;
      nmi_pulse <= hit2 && !ev2_q && nmi_en;
    end
  end

  always_comb begin
    setup_rd                 = '0;
    setup_rd[DIV_W-1:0]      = cfg_q.div;
    setup_rd[BIT_CLKSEL]     = cfg_q.clk_sel;
    setup_rd[BIT_C1EN]       = cfg_q.c1_en;
    setup_rd[BIT_C2EN]       = cfg_q.c2_en;
    setup_rd[BIT_EV1]        = ev1_q;
    setup_rd[BIT_EV2]        = ev2_q;
    setup_rd[BIT_RUN]        = run_q;
  end
endmodule

// File: rtl/mfgt_bank.sv
module mfgt_bank
  import mfgt_pkg::*;
#(
  parameter int NUM_TIMERS = 6,
  localparam int IDX_W  = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W = IDX_W + 2,
  localparam int PH_W   = (1 << DIV_W) - 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  ref_tick,
  input  logic [NUM_TIMERS-1:0] rst_enable,
  input  logic [NUM_TIMERS-1:0] nmi_enable,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  reset_req,
  output logic                  nmi_req
);
  logic [IDX_W-1:0] idx;
  logic [1:0]       sel;
  logic [NUM_TIMERS-1:0][DATA_W-1:0] setup_view, count_view, cmp1_view, cmp2_view;
  logic [NUM_TIMERS-1:0] rst_pulse_v, nmi_pulse_v;
  logic [DATA_W-1:0] rd_mux;

  assign idx = bus_addr[ADDR_W-1:2];
  assign sel = bus_addr[1:0];

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    mfgt_channel #(.PH_W(PH_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .sel_wr    (bus_wr && (idx == IDX_W'(g))),
      .wr_reg    (sel),
      .wdata     (bus_wdata),
      .ref_tick  (ref_tick),
      .rst_en    (rst_enable[g]),
      .nmi_en    (nmi_enable[g]),
      .setup_rd  (setup_view[g]),
      .count_q   (count_view[g]),
      .cmp1_q    (cmp1_view[g]),
      .cmp2_q    (cmp2_view[g]),
      .rst_pulse (rst_pulse_v[g]),
      .nmi_pulse (nmi_pulse_v[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (idx == IDX_W'(i)) begin
        case (sel)
          SEL_SETUP: rd_mux = setup_view[i];
          SEL_COUNT: rd_mux = count_view[i];
          SEL_CMP1:  rd_mux = cmp1_view[i];
          default:   rd_mux = cmp2_view[i];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign reset_req = |rst_pulse_v;
  assign nmi_req   = |nmi_pulse_v;
endmodule

// File: rtl/mfgt_bank_checker.sv
module mfgt_bank_checker #(
  parameter int NUM_TIMERS = 6,
  localparam int IDX_W  = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [15:0]           bus_wdata,
  input logic [NUM_TIMERS-1:0] rst_enable,
  input logic [NUM_TIMERS-1:0] nmi_enable,
  input logic [NUM_TIMERS-1:0][15:0] setup_view,
  input logic [NUM_TIMERS-1:0][15:0] count_view,
  input logic [NUM_TIMERS-1:0] rst_pulse_v,
  input logic [NUM_TIMERS-1:0] nmi_pulse_v
);
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    (rst_pulse_v & $past(rst_pulse_v)) == '0);

  p_reset_gated_r8: assert property (@(posedge clk) disable iff (rst)
    (rst_pulse_v & ~$past(rst_enable)) == '0);

  p_nmi_gated_r9: assert property (@(posedge clk) disable iff (rst)
    (nmi_pulse_v & ~$past(nmi_enable)) == '0);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] A_SETUP = ADDR_W'(i * 4);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(i * 4 + 1);

    p_pulse_on_edge_r8: assert property (@(posedge clk) disable iff (rst)
      rst_pulse_v[i] |-> (setup_view[i][14] && !$past(setup_view[i][14])));

    p_cfg_fixed_r3: assert property (@(posedge clk) disable iff (rst)
      ($past(setup_view[i][6:0]) != 7'd0) |-> $stable(setup_view[i][6:0]));

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(setup_view[i][14]) |-> $past(bus_wr && bus_addr == A_SETUP && bus_wdata[14]));

    p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
      (!$past(setup_view[i][15]) && !$past(bus_wr && bus_addr == A_COUNT))
        |-> $stable(count_view[i]));
  end
endmodule

bind mfgt_bank mfgt_bank_checker #(.NUM_TIMERS(NUM_TIMERS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .rst_enable  (rst_enable),
  .nmi_enable  (nmi_enable),
  .setup_view  (setup_view),
  .count_view  (count_view),
  .rst_pulse_v (rst_pulse_v),
  .nmi_pulse_v (nmi_pulse_v)
);

// File: tb/mfgt_bank_test.sv
`timescale 1ns/1ps
module mfgt_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        ref_tick = 1'b0;
  logic [5:0]  rst_enable = '0, nmi_enable = '0;
  logic [15:0] bus_rdata;
  logic        reset_req, nmi_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mfgt_bank uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ref_tick(ref_tick), .rst_enable(rst_enable),
    .nmi_enable(nmi_enable), .bus_rdata(bus_rdata), .reset_req(reset_req),
    .nmi_req(nmi_req)
  );

  typedef struct packed {
    logic [7:0]  tmr;
    logic [15:0] setup;
    logic [15:0] start;
    logic [7:0]  steps;
    logic        ref_lvl;
    logic [15:0] exp_cnt;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'd0, 16'h0010, 16'h0000, 8'd10, 1'b0, 16'h000A},
    '{8'd1, 16'h0012, 16'h0005, 8'd13, 1'b0, 16'h0008},
    '{8'd2, 16'h0010, 16'hFFFC, 8'd9,  1'b0, 16'hFFFF},
    '{8'd3, 16'h0003, 16'h0100, 8'd40, 1'b1, 16'h0105}
  };

  function automatic logic [4:0] ad(input int t, input int s);
    return {t[2:0], s[1:0]};
  endfunction

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic run(input int t, input int k);
    wr(ad(t, 0), 16'h8000);
    repeat (k - 1) @(negedge clk);
    wr(ad(t, 0), 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int hits, at, nhits;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1", reset_req, 0, "reset_req after reset");
    chk("R1", nmi_req, 0, "nmi_req after reset");
    for (int t = 0; t < 6; t++)
      for (int s = 0; s < 4; s++) begin
        rd(ad(t, s), d);
        chk("R1", d, 0, "register after reset");
      end

    // R12: out-of-range index
    wr(ad(6, 1), 16'h1234);
    wr(ad(7, 3), 16'hBEEF);
    rd(ad(6, 1), d);
    chk("R12", d, 0, "read of absent timer");
    for (int t = 0; t < 6; t++) begin
      rd(ad(t, 1), d);
      chk("R12", d, 0, "count untouched by absent-timer write");
    end

    // R4 / R10: table of counting runs
    foreach (VECS[i]) begin
      wr(ad(VECS[i].tmr, 0), VECS[i].setup);
      wr(ad(VECS[i].tmr, 1), VECS[i].start);
      ref_tick = VECS[i].ref_lvl;
      run(VECS[i].tmr, VECS[i].steps);
      rd(ad(VECS[i].tmr, 1), d);
      chk(VECS[i].exp_cnt == 16'hFFFF ? "R10" : "R4", d, VECS[i].exp_cnt, "count after run");
    end

    // R5: freeze and resume
    repeat (5) @(negedge clk);
    rd(ad(0, 1), d);
    chk("R5", d, 16'h000A, "frozen count");
    run(0, 4);
    rd(ad(0, 1), d);
    chk("R5", d, 16'h000E, "resumed count");

    // R2 / R3: write-once setup
    wr(ad(4, 0), 16'h0070);
    rd(ad(4, 0), d);
    chk("R2", d, 16'h0070, "first setup write");
    wr(ad(4, 0), 16'h000F);
    rd(ad(4, 0), d);
    chk("R3", d, 16'h0070, "config after second write");
    wr(ad(4, 2), 16'd2);
    wr(ad(4, 3), 16'd5);
    rd(ad(4, 2), d);
    chk("R12", d, 2, "compare 1 readback");
    rd(ad(4, 3), d);
    chk("R12", d, 5, "compare 2 readback");

    // R6 / R8: match, single reset pulse six cycles after enable
    wr(ad(4, 1), 16'd0);
    rst_enable = 6'b010000;
    nmi_enable = 6'b000000;
    hits = 0; at = -1; nhits = 0;
    wr(ad(4, 0), 16'h8000);
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      if (reset_req) begin hits++; at = c; end
      if (nmi_req) nhits++;
    end
    wr(ad(4, 0), 16'h0000);
    chk("R8", hits, 1, "reset pulse count");
    chk("R8", at, 6, "reset pulse cycle");
    chk("R9", nhits, 0, "nmi pulses while masked");
    rd(ad(4, 0), d);
    chk("R6", d, 16'h6070, "both events set, zero write leaves them (R7)");

    // R7: write-one-to-clear
    wr(ad(4, 0), 16'h4000);
    rd(ad(4, 0), d);
    chk("R7", d, 16'h2070, "clear compare-2 event only");
    wr(ad(4, 0), 16'h2000);
    rd(ad(4, 0), d);
    chk("R7", d, 16'h0070, "clear compare-1 event");

    // R9 / R6: nmi path, counter returns to zero
    rst_enable = 6'b000000;
    nmi_enable = 6'b010000;
    wr(ad(4, 1), 16'd3);
    run(4, 3);
    chk("R9", nmi_req, 1, "nmi pulse on flag edge");
    chk("R8", reset_req, 0, "no reset pulse with enable clear");
    rd(ad(4, 1), d);
    chk("R6", d, 0, "count restarts after compare 2");
    rd(ad(4, 0), d);
    chk("R6", d, 16'h4070, "compare-2 event set");

    // R11: counter write on the matching cycle
    rst_enable = 6'b100000;
    nmi_enable = 6'b000000;
    wr(ad(5, 0), 16'h0050);
    wr(ad(5, 3), 16'd7);
    wr(ad(5, 1), 16'd0);
    hits = 0;
    wr(ad(5, 0), 16'h8000);
    for (int c = 0; c < 7; c++) begin
      @(negedge clk);
      if (reset_req) hits++;
    end
    wr(ad(5, 1), 16'h0020);
    wr(ad(5, 0), 16'h0000);
    if (reset_req) hits++;
    rd(ad(5, 1), d);
    chk("R11", d, 16'h0021, "written value wins over stale match");
    rd(ad(5, 0), d);
    chk("R11", d, 16'h0050, "no event from suppressed compare");
    chk("R11", hits, 0, "no reset pulse from suppressed compare");

    // R4 / R3: reference strobes gated off, run bit readback
    ref_tick = 1'b0;
    run(3, 20);
    rd(ad(3, 1), d);
    chk("R4", d, 16'h0105, "no count without reference strobes");
    wr(ad(3, 0), 16'h8000);
    rd(ad(3, 0), d);
    chk("R3", d, 16'h8003, "run bit writable after lock");
    wr(ad(3, 0), 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule